// File: doc/BRIEF.md
# PMBus Target Byte Engine

This block is the bus-facing half of a PMBus/I2C target. It watches the open-drain clock and data lines through synchronizers, finds start and stop conditions, matches a 7-bit own address and pulls the data line low to acknowledge. Short writes are gathered into a small buffer and acknowledged by the hardware alone, so the processor only sees a finished message with its byte count. A write longer than the buffer holds the clock low until the processor frees it.

Two PMBus additions sit beside the byte engine. A clock-low watchdog flags a bus that has been stuck low for too long. It can be turned off for plain I2C use. An alert path drives an ALERT output low and, unless manual acknowledge is selected, answers a read to the alert response address by itself. It replies with its own address and drops out cleanly when another responder wins the bitwise arbitration.

Top module: `smb_target`

## Requirements
- R1: An address byte equal to `{own_addr, 1'b0}` is acknowledged: the design pulls SDA low through the whole ninth clock pulse.
- R2: Any other address byte is not acknowledged, and the rest of that transfer is ignored until the next start or stop. This includes a read of the own address, and an alert response read that is not being answered. The design does not drive SDA, does not stretch SCL and does not emit `rx_done` for it.
- R3: Up to NB bytes of an own-address write (NB = 4 by default) are stored without stretching SCL, and each byte is acknowledged. The first byte is the command and appears in `rx_data[7:0]`; byte i appears in `rx_data[8i+7:8i]`. On the following stop or repeated start, `rx_done` pulses for one cycle while `rx_count` gives the number of whole bytes.
- R4: A data byte that arrives while NB bytes are already held makes the design hold SCL low after its eighth bit until `hold_release` pulses. The buffer then starts over with that byte alone (count 1), and the byte is acknowledged.
- R5: When SCL has been low for TMO_CYC = CLK_KHZ*TMO_MS consecutive clock cycles, `tmo_flag` pulses once. The design then releases both lines and goes idle. With `tmo_dis` high, no timeout is flagged.
- R6: `alert_low` is high while `alert_en` is high and the alert has not yet been answered. It is low while `alert_en` is low, and clearing `alert_en` re-arms the alert.
- R7: With `alert_en` high and `man_ack` low, a read of the alert response address 7'b0001100 (address byte 0x19) is acknowledged. The design then sends `{own_addr, 1'b0}` MSB first. After all eight bits are sent without loss, `alert_low` falls.
- R8: With `man_ack` high, the alert response address byte is not acknowledged, and `alert_low` stays high.
- R9: If SDA reads low at a rising SCL edge while the design is sending a 1 bit of its alert reply, it stops driving SDA for the rest of the transfer. It pulses `arb_lost` and keeps `alert_low` high.
- R10: A stop in the middle of a byte returns the design to idle with both lines released. The partial byte is not stored, and the next transfer is handled normally.
- R11: A repeated start restarts address matching, so a not-acknowledged address can be followed by an own-address transfer without a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| alert_low | output | 1 | 1 pulls the ALERT line low |
| own_addr | input | 7 | Own 7-bit address |
| tmo_dis | input | 1 | Disables the clock-low timeout |
| alert_en | input | 1 | Requests an alert |
| man_ack | input | 1 | Leaves the alert response to software (no hardware acknowledge) |
| hold_release | input | 1 | One-cycle pulse that ends a buffer-full clock stretch |
| rx_data | output | NB*8 | Received bytes, command byte lowest |
| rx_count | output | $clog2(NB+1) | Number of whole bytes held |
| rx_done | output | 1 | One-cycle pulse at the end of a write with data |
| tmo_flag | output | 1 | One-cycle pulse on a clock-low timeout |
| arb_lost | output | 1 | One-cycle pulse when alert arbitration is lost |

## Verification
The bench builds the block with NB = 4, CLK_KHZ = 4 and TMO_MS = 35. This makes the timeout 140 cycles, so a stuck-low clock can be held past the limit in a few hundred cycles, while every normal bit keeps SCL low for far fewer cycles. With NB = 4, a single five-byte write reaches the buffer-full stretch and the restart with a count of 1. A modelled second responder with a lower address makes arbitration loss happen on the first reply bit.

// File: rtl/smb_pkg.sv
package smb_pkg;
  // reserved address that every alerting target answers
  localparam logic [6:0] ARA_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_DATA,
    ST_HOLD,
    ST_ATX,
    ST_SKIP
  } smb_st_e;
endpackage

// File: rtl/smb_lines.sv
module smb_lines #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [SYNC-1:0] scl_pipe, sda_pipe;
  logic            scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC-1];
      sda_q    <= sda_pipe[SYNC-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC-1];
  assign sda_s     = sda_pipe[SYNC-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data edges while the clock stays high frame a transfer
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_tmo.sv
module smb_tmo #(
  parameter int TMO_CYC = 4375000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic tmo_dis,
  output logic tmo
);
  localparam int TW = $clog2(TMO_CYC + 1);
  logic [TW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      tmo     <= 1'b0;
    end else begin
      tmo <= 1'b0;
      if (scl_s || tmo_dis) begin
        low_cnt <= '0;
      end else if (low_cnt != TW'(TMO_CYC)) begin
        low_cnt <= low_cnt + 1'b1;
        if (low_cnt == TW'(TMO_CYC - 1)) tmo <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/smb_rxbuf.sv
module smb_rxbuf #(
  parameter int NB = 4,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            wr,
  input  logic [7:0]      din,
  output logic [NB*8-1:0] dout,
  output logic [CW-1:0]   count,
  output logic            full
);
  logic [CW-1:0] slot;
  assign slot = clr ? '0 : count;
  assign full = (count == CW'(NB));

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (clr) count <= wr ? CW'(1) : '0;
    else if (wr)  count <= count + 1'b1;
  end

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)                         dout[g*8 +: 8] <= '0;
      else if (wr && slot == CW'(g))   dout[g*8 +: 8] <= din;
    end
  end
endmodule

// File: rtl/smb_core.sv
module smb_core
  import smb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       tmo,
  input  logic [6:0] own_addr,
  input  logic       alert_en,
  input  logic       man_ack,
  input  logic       hold_release,
  input  logic       buf_full,
  input  logic       buf_any,
  output logic       buf_clr,
  output logic       buf_wr,
  output logic [7:0] buf_byte,
  output logic       sda_oe,
  output logic       scl_oe,
  output logic       alert_low,
  output logic       rx_done,
  output logic       arb_lost
);
  smb_st_e    st;
  logic [3:0] bit_cnt;
  logic [7:0] sr, txb;
  logic       is_ara, is_wr, served;
  logic       hit_wr, hit_ara;

  assign hit_wr  = (sr[7:1] == own_addr) && !sr[0];
  assign hit_ara = alert_en && !man_ack && !served &&
                   (sr[7:1] == ARA_ADDR) && sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      sr        <= '0;
      txb       <= '0;
      is_ara    <= 1'b0;
      is_wr     <= 1'b0;
      served    <= 1'b0;
      sda_oe    <= 1'b0;
      scl_oe    <= 1'b0;
      alert_low <= 1'b0;
      rx_done   <= 1'b0;
      arb_lost  <= 1'b0;
      buf_clr   <= 1'b0;
      buf_wr    <= 1'b0;
      buf_byte  <= '0;
    end else begin
      buf_clr   <= 1'b0;
      buf_wr    <= 1'b0;
      rx_done   <= 1'b0;
      arb_lost  <= 1'b0;
      alert_low <= alert_en & ~served;
      if (!alert_en) served <= 1'b0;

      if (tmo) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
        is_wr  <= 1'b0;
      end else if (bus_start || bus_stop) begin
        st      <= bus_start ? ST_ADDR : ST_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        scl_oe  <= 1'b0;
        if (is_wr && buf_any) rx_done <= 1'b1;
        is_wr   <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_DATA: begin
            if (scl_rise) begin
              sr      <= {sr[6:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (st == ST_DATA) begin
                buf_byte <= sr;
                if (buf_full) begin
                  scl_oe <= 1'b1;
                  st     <= ST_HOLD;
                end else begin
                  buf_wr <= 1'b1;
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                end
              end else if (hit_wr) begin
                buf_clr <= 1'b1;
                is_wr   <= 1'b1;
                is_ara  <= 1'b0;
                sda_oe  <= 1'b1;
                st      <= ST_ACK;
              end else if (hit_ara) begin
                is_ara  <= 1'b1;
                txb     <= {own_addr, 1'b0};
                sda_oe  <= 1'b1;
                st      <= ST_ACK;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_HOLD: begin
            if (hold_release) begin
              buf_clr <= 1'b1;
              buf_wr  <= 1'b1;
              sda_oe  <= 1'b1;
              scl_oe  <= 1'b0;
              st      <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (is_ara) begin
                sda_oe <= ~txb[7];
                st     <= ST_ATX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_DATA;
              end
            end
          end
          ST_ATX: begin
            if (scl_rise && txb[7] && !sda_s) begin
              sda_oe   <= 1'b0;
              arb_lost <= 1'b1;
              st       <= ST_SKIP;
            end else if (scl_fall) begin
              txb     <= {txb[6:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == 4'd7) begin
                sda_oe <= 1'b0;
                served <= 1'b1;
                st     <= ST_SKIP;
              end else begin
                sda_oe <= ~txb[6];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_target.sv
module smb_target #(
  parameter int NB      = 4,
  parameter int CLK_KHZ = 125000,
  parameter int TMO_MS  = 35,
  parameter int SYNC    = 2,
  localparam int CW     = $clog2(NB + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic            alert_low,
  input  logic [6:0]      own_addr,
  input  logic            tmo_dis,
  input  logic            alert_en,
  input  logic            man_ack,
  input  logic            hold_release,
  output logic [NB*8-1:0] rx_data,
  output logic [CW-1:0]   rx_count,
  output logic            rx_done,
  output logic            tmo_flag,
  output logic            arb_lost
);
  localparam int TMO_CYC = CLK_KHZ * TMO_MS;

  logic       scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic       buf_clr, buf_wr, buf_full;
  logic [7:0] buf_byte;

  smb_lines #(.SYNC(SYNC)) u_lines (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  smb_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk(clk), .rst(rst), .scl_s(scl_s), .tmo_dis(tmo_dis), .tmo(tmo_flag)
  );

  smb_rxbuf #(.NB(NB)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .wr(buf_wr), .din(buf_byte),
    .dout(rx_data), .count(rx_count), .full(buf_full)
  );

  smb_core u_core (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .tmo(tmo_flag), .own_addr(own_addr), .alert_en(alert_en),
    .man_ack(man_ack), .hold_release(hold_release), .buf_full(buf_full),
    .buf_any(rx_count != '0), .buf_clr(buf_clr), .buf_wr(buf_wr),
    .buf_byte(buf_byte), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .alert_low(alert_low), .rx_done(rx_done), .arb_lost(arb_lost)
  );
endmodule

// File: rtl/smb_target_chk.sv
module smb_target_chk #(
  parameter int NB = 4,
  localparam int CW = $clog2(NB + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          scl_oe,
  input logic          alert_low,
  input logic          alert_en,
  input logic          tmo_dis,
  input logic [CW-1:0] rx_count,
  input logic          rx_done,
  input logic          tmo_flag,
  input logic          arb_lost
);
  p_ack_scl_low_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    rx_count <= CW'(NB));

  p_done_has_data_r3: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> rx_count != '0);

  p_stretch_full_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> rx_count == CW'(NB));

  p_tmo_gate_r5: assert property (@(posedge clk) disable iff (rst)
    tmo_flag |-> $past(!tmo_dis));

  p_tmo_release_r5: assert property (@(posedge clk) disable iff (rst)
    tmo_flag |=> (!sda_oe && !scl_oe));

  p_alert_gate_r6: assert property (@(posedge clk) disable iff (rst)
    alert_low |-> $past(alert_en));

  p_arb_release_r9: assert property (@(posedge clk) disable iff (rst)
    arb_lost |-> !sda_oe);
endmodule

bind smb_target smb_target_chk #(.NB(NB)) u_chk (.*);

// File: tb/smb_target_test.sv
module smb_target_test;
  localparam int NB = 4;
  localparam int CW = $clog2(NB + 1);
  localparam int H  = 10;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, sda_other = 1'b1;
  logic tmo_dis = 1'b0, alert_en = 1'b0, man_ack = 1'b0, hold_release = 1'b0;
  logic scl_oe, sda_oe, alert_low, rx_done, tmo_flag, arb_lost;
  logic [NB*8-1:0] rx_data;
  logic [CW-1:0]   rx_count;
  wire scl_bus = scl_m & ~scl_oe;
  wire sda_bus = sda_m & ~sda_oe & sda_other;

  smb_target #(.NB(NB), .CLK_KHZ(4), .TMO_MS(35)) uut (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .alert_low(alert_low),
    .own_addr(OWN), .tmo_dis(tmo_dis), .alert_en(alert_en),
    .man_ack(man_ack), .hold_release(hold_release), .rx_data(rx_data),
    .rx_count(rx_count), .rx_done(rx_done), .tmo_flag(tmo_flag),
    .arb_lost(arb_lost)
  );

  int n_run = 0, n_fail = 0;
  int stretch_cyc = 0, tmo_cnt = 0, arb_cnt = 0;

  typedef struct { int cnt; logic [NB*8-1:0] data; string tag; } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_msg(input int cnt, input logic [NB*8-1:0] d,
                            input string tag);
    exp_t e;
    e.cnt = cnt; e.data = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: scoreboard on rx_done plus event counters
  always @(negedge clk) begin
    if (!rst) begin
      if (scl_oe)   stretch_cyc++;
      if (tmo_flag) tmo_cnt++;
      if (arb_lost) arb_cnt++;
      if (rx_done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected rx_done count", rx_count, 0);
        end else begin
          exp_t e;
          logic [NB*8-1:0] mask;
          e = exp_q.pop_front();
          mask = (e.cnt >= NB) ? '1 : ((NB*8)'(1) << (e.cnt * 8)) - 1'b1;
          check(rx_count == CW'(e.cnt), e.tag, "rx_count", rx_count, e.cnt);
          check((rx_data & mask) == (e.data & mask), e.tag, "rx_data",
                rx_data & mask, e.data & mask);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; cyc(H);
    scl_m = 1'b1; wait (scl_bus == 1'b1); cyc(H);
    sda_m = 1'b0; cyc(H);
    scl_m = 1'b0; cyc(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; cyc(H);
    scl_m = 1'b1; wait (scl_bus == 1'b1); cyc(H);
    sda_m = 1'b1; cyc(H);
  endtask

  task automatic clock_bit(input logic b, output logic r);
    sda_m = b; cyc(H);
    scl_m = 1'b1; wait (scl_bus == 1'b1); cyc(H/2);
    r = sda_bus; cyc(H/2);
    scl_m = 1'b0; cyc(5);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
    clock_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv(input logic [7:0] other, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      sda_other = other[i];
      clock_bit(1'b1, r);
      v[i] = r;
    end
    sda_other = 1'b1;
    clock_bit(1'b1, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] v;
    cyc(5);
    rst = 1'b0;
    cyc(5);
    check(!sda_oe && !scl_oe, "R1", "reset line drive", {sda_oe, scl_oe}, 0);
    check(rx_count == 0, "R3", "reset rx_count", rx_count, 0);
    check(!alert_low, "R6", "reset alert_low", alert_low, 0);

    // R1 / R3: full four-byte write, no stretch
    stretch_cyc = 0;
    expect_msg(4, 32'h43321021, "R3");
    bus_start(); send({OWN, 1'b0}, ack);
    check(ack, "R1", "own address ack", ack, 1);
    send(8'h21, ack); check(ack, "R3", "cmd ack", ack, 1);
    send(8'h10, ack); check(ack, "R3", "data1 ack", ack, 1);
    send(8'h32, ack); check(ack, "R3", "data2 ack", ack, 1);
    send(8'h43, ack); check(ack, "R3", "data3 ack", ack, 1);
    bus_stop(); cyc(10);
    check(stretch_cyc == 0, "R3", "no stretch cycles", stretch_cyc, 0);

    // R3: two-byte write
    expect_msg(2, 32'h0000817E, "R3");
    bus_start(); send({OWN, 1'b0}, ack);
    send(8'h7E, ack); send(8'h81, ack);
    check(ack, "R3", "second byte ack", ack, 1);
    bus_stop(); cyc(10);

    // R2: foreign address and own-address read are ignored
    bus_start(); send(8'h30, ack);
    check(!ack, "R2", "foreign address nack", ack, 0);
    send(8'h55, ack);
    check(!ack, "R2", "byte after foreign address", ack, 0);
    bus_stop(); cyc(5);
    bus_start(); send({OWN, 1'b1}, ack);
    check(!ack, "R2", "own read nack", ack, 0);
    bus_stop(); cyc(10);

    // R4: fifth byte stretches until release, buffer restarts
    expect_msg(1, 32'h00000099, "R4");
    bus_start(); send({OWN, 1'b0}, ack);
    send(8'h01, ack); send(8'h02, ack); send(8'h03, ack); send(8'h04, ack);
    stretch_cyc = 0;
    fork
      send(8'h99, ack);
      begin
        wait (scl_oe == 1'b1);
        cyc(50);
        hold_release = 1'b1; cyc(1); hold_release = 1'b0;
      end
    join
    check(ack, "R4", "stretched byte ack", ack, 1);
    check(stretch_cyc >= 50, "R4", "stretch length", stretch_cyc, 50);
    bus_stop(); cyc(10);

    // R10: stop in mid-byte
    expect_msg(1, 32'h00000066, "R10");
    bus_start(); send({OWN, 1'b0}, ack); send(8'h66, ack);
    clock_bit(1'b1, ack); clock_bit(1'b0, ack); clock_bit(1'b1, ack);
    bus_stop(); cyc(10);
    check(!sda_oe && !scl_oe, "R10", "lines released", {sda_oe, scl_oe}, 0);
    expect_msg(1, 32'h000000A5, "R10");
    bus_start(); send({OWN, 1'b0}, ack);
    check(ack, "R10", "next transfer ack", ack, 1);
    send(8'hA5, ack); bus_stop(); cyc(10);

    // R11: repeated start restarts matching
    expect_msg(1, 32'h0000003C, "R11");
    bus_start(); send(8'h30, ack);
    bus_start(); send({OWN, 1'b0}, ack);
    check(ack, "R11", "ack after repeated start", ack, 1);
    send(8'h3C, ack); bus_stop(); cyc(10);

    // R5: clock-low timeout, enabled then disabled
    tmo_cnt = 0;
    bus_start(); send({OWN, 1'b0}, ack);
    cyc(180);
    check(tmo_cnt == 1, "R5", "timeout pulses", tmo_cnt, 1);
    check(!sda_oe && !scl_oe, "R5", "released after timeout", {sda_oe, scl_oe}, 0);
    bus_stop(); cyc(10);
    tmo_dis = 1'b1; tmo_cnt = 0;
    bus_start(); send({OWN, 1'b0}, ack);
    cyc(200);
    check(tmo_cnt == 0, "R5", "timeout disabled", tmo_cnt, 0);
    bus_stop(); cyc(10);
    tmo_dis = 1'b0;

    // R6 / R8: alert asserted, manual acknowledge leaves it to software
    alert_en = 1'b1; cyc(3);
    check(alert_low, "R6", "alert driven", alert_low, 1);
    man_ack = 1'b1;
    bus_start(); send(8'h19, ack);
    check(!ack, "R8", "manual mode nack", ack, 0);
    bus_stop(); cyc(5);
    check(alert_low, "R8", "alert kept", alert_low, 1);
    man_ack = 1'b0;

    // R7: hardware alert reply
    bus_start(); send(8'h19, ack);
    check(ack, "R7", "alert address ack", ack, 1);
    recv(8'hFF, v);
    check(v == {OWN, 1'b0}, "R7", "alert reply", v, {OWN, 1'b0});
    bus_stop(); cyc(5);
    check(!alert_low, "R7", "alert cleared after reply", alert_low, 0);

    // R6: disable then re-arm
    alert_en = 1'b0; cyc(3);
    check(!alert_low, "R6", "alert released when disabled", alert_low, 0);
    alert_en = 1'b1; cyc(3);
    check(alert_low, "R6", "alert re-armed", alert_low, 1);

    // R9: lower address wins arbitration
    arb_cnt = 0;
    bus_start(); send(8'h19, ack);
    recv(8'h30, v);
    check(v == 8'h30, "R9", "winner on bus", v, 8'h30);
    check(arb_cnt == 1, "R9", "arb_lost pulses", arb_cnt, 1);
    check(!sda_oe, "R9", "sda released", sda_oe, 0);
    bus_stop(); cyc(5);
    check(alert_low, "R9", "alert kept after loss", alert_low, 1);

    check(exp_q.size() == 0, "R3", "messages left in scoreboard", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule